// File: doc/BRIEF.md
# Cache Slice Event Counter Monitor

This block watches a shared cache slice for performance events and counts them in eight programmable counters. The cache logic supplies a vector of single-cycle event pulses. Each bit's position in that vector is its event code. Every counter has an 8-bit code selector that picks one bit of the vector. A counter advances only when a global run bit and its own enable bit are both set.

Software reaches the block through a simple register port. The port has one address, one write strobe, one write data word and a combinational read data word. Control registers use the low 32 bits of the data word. Counters are read and written as full 64-bit slots. The value is 48 bits and the upper bits read as zero.

When a counter wraps, a sticky status bit is set. Software clears it by writing a one. A per-counter mask decides whether a set status bit drives the single level interrupt output.

Top module: `cache_perfmon`

## Requirements
- R1: After reset every counter reads 0. The enable register (0x1C00), the control register (0x0408), the status register (0x0808) and `irq` are all 0. The mask register (0x0800) reads 0xFF. Both selector words (0x1D00, 0x1D04) read 0xFFFFFFFF.
- R2: Counter n advances by one on each clock edge where its selected event pulse is high, bit 17 of the control register (0x0408) is set and bit n of the enable register (0x1C00) is set. Only bit 17 of the control register and bits 7:0 of the enable register are stored.
- R3: A counter holds its value while bit 17 of 0x0408 is clear or while its own enable bit is clear.
- R4: Counters 0 to 3 take their selector from the word at 0x1D00 and counters 4 to 7 from the word at 0x1D04. Counter n uses bits [8*(n%4)+7 : 8*(n%4)]. A selector value c picks bit c of `evt_pulse`.
- R5: Selector value 0xFF selects no event, so the counter never increments, even when bit 255 of `evt_pulse` is high.
- R6: Counter n is the 64-bit slot at 0x1E00 + 8*n. A write loads bits 47:0 and ignores bits 63:48. A read returns the 48-bit value with bits 63:48 equal to zero.
- R7: A software write to a counter in the same cycle as an increment loads the written value, and the increment is lost.
- R8: When counter n wraps from all ones to zero, status bit n (register 0x0808) is set on the same clock edge. This happens whether or not the counter's interrupt is masked.
- R9: Writing 1 to bit n of 0x080C clears status bit n, and writing 0 has no effect. Writes to 0x0808 itself change nothing. If a wrap and a clear hit the same bit in the same cycle, the bit stays set.
- R10: `irq` is high exactly when some status bit is set and its bit in the mask register 0x0800 is 0; a mask bit of 1 blocks that counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 16 | Byte address of the register or counter slot |
| bus_wdata | input | 64 | Write data; control registers use bits 31:0 |
| bus_rdata | output | 64 | Combinational read data for `bus_addr` |
| evt_pulse | input | 256 | Event pulses, bit index equals event code |
| irq | output | 1 | Level interrupt: unmasked overflow pending |

## Verification
The assertions assume two things about the inputs. First, each register access is a single-cycle strobe whose address and data are stable across the clock edge. Second, event pulses are plain per-cycle levels, with nothing implied by bit 255. The counter properties also assume that a write to one counter slot never coincides with a write to another register that changes its run state. The bench keeps within these assumptions in two ways. It changes the address, data, strobe and event bits only on the falling edge, and it performs one access at a time. The only deliberate overlaps are an event pulse with a counter write, and a wrap with a status clear, because those two collisions are requirements in their own right.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
    localparam int OFS_CTRL   = 'h0408;
    localparam int OFS_MASK   = 'h0800;
    localparam int OFS_STAT   = 'h0808;
    localparam int OFS_CLR    = 'h080C;
    localparam int OFS_EVEN   = 'h1C00;
    localparam int OFS_SEL    = 'h1D00;
    localparam int OFS_CNT    = 'h1E00;
    localparam int RUN_BIT    = 17;
    localparam int CTRL_W     = 32;
    localparam int SLOT_BYTES = 8;
endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
    parameter int CNT_W   = 48,
    parameter int SEL_W   = 8,
    parameter int NUM_EVT = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               wr_en,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   cnt,
    output logic               wrap
);
    localparam logic [SEL_W-1:0] SEL_NONE = '1;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = run && (sel != SEL_NONE) && evt[sel];
        wrap = hit && !wr_en && (st_q.value == CNT_MAX);
        if (wr_en)
            st_d.value = wr_data;
        else if (hit)
            st_d.value = st_q.value + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.value;

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(cnt));

    p_none_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE && !wr_en) |=> $stable(cnt));

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt == $past(wr_data)));

    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));
endmodule

// File: rtl/perfmon_regs.sv
module perfmon_regs
    import perfmon_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int SEL_W   = 8,
    parameter int ADDR_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [CTRL_W-1:0]        wdata,
    input  logic [NUM_CNT-1:0]       wrap,
    output logic                     run_all,
    output logic [NUM_CNT-1:0]       cnt_en,
    output logic [NUM_CNT-1:0]       mask,
    output logic [NUM_CNT-1:0]       status,
    output logic [NUM_CNT*SEL_W-1:0] sel,
    output logic [CTRL_W-1:0]        rdata
);
    localparam int LANES     = CTRL_W / SEL_W;
    localparam int SEL_WORDS = (NUM_CNT + LANES - 1) / LANES;

    typedef struct packed {
        logic                     run;
        logic [NUM_CNT-1:0]       en;
        logic [NUM_CNT-1:0]       msk;
        logic [NUM_CNT-1:0]       stat;
        logic [NUM_CNT*SEL_W-1:0] sel;
    } reg_state_t;

    reg_state_t         r_d, r_q;
    logic [NUM_CNT-1:0] clr_vec;

    always_comb begin
        r_d     = r_q;
        clr_vec = '0;
        if (wr_en) begin
            if (addr == ADDR_W'(OFS_CTRL)) r_d.run = wdata[RUN_BIT];
            if (addr == ADDR_W'(OFS_EVEN)) r_d.en  = wdata[NUM_CNT-1:0];
            if (addr == ADDR_W'(OFS_MASK)) r_d.msk = wdata[NUM_CNT-1:0];
            if (addr == ADDR_W'(OFS_CLR))  clr_vec = wdata[NUM_CNT-1:0];
            for (int w = 0; w < SEL_WORDS; w++) begin
                if (addr == ADDR_W'(OFS_SEL + 4 * w)) begin
                    for (int l = 0; l < LANES; l++) begin
                        if (w * LANES + l < NUM_CNT)
                            r_d.sel[(w*LANES+l)*SEL_W +: SEL_W] = wdata[l*SEL_W +: SEL_W];
                    end
                end
            end
        end
        r_d.stat = (r_q.stat & ~clr_vec) | wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.run  <= 1'b0;
            r_q.en   <= '0;
            r_q.msk  <= '1;
            r_q.stat <= '0;
            r_q.sel  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CTRL)) rdata[RUN_BIT]       = r_q.run;
        if (addr == ADDR_W'(OFS_EVEN)) rdata[NUM_CNT-1:0]   = r_q.en;
        if (addr == ADDR_W'(OFS_MASK)) rdata[NUM_CNT-1:0]   = r_q.msk;
        if (addr == ADDR_W'(OFS_STAT)) rdata[NUM_CNT-1:0]   = r_q.stat;
        for (int w = 0; w < SEL_WORDS; w++) begin
            if (addr == ADDR_W'(OFS_SEL + 4 * w)) begin
                for (int l = 0; l < LANES; l++) begin
                    if (w * LANES + l < NUM_CNT)
                        rdata[l*SEL_W +: SEL_W] = r_q.sel[(w*LANES+l)*SEL_W +: SEL_W];
                    else
                        rdata[l*SEL_W +: SEL_W] = '1;
                end
            end
        end
    end

    assign run_all = r_q.run;
    assign cnt_en  = r_q.en;
    assign mask    = r_q.msk;
    assign status  = r_q.stat;
    assign sel     = r_q.sel;

    p_wrap_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> (($past(wrap) & ~status) == '0));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ~clr_vec)) |=> (($past(status & ~clr_vec) & ~status) == '0));
endmodule

// File: rtl/cache_perfmon.sv
module cache_perfmon
    import perfmon_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 48,
    parameter int SEL_W   = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 64,
    parameter int NUM_EVT = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq
);
    logic                     run_all;
    logic [NUM_CNT-1:0]       cnt_en, mask, status, wrap, slot_hit;
    logic [NUM_CNT*SEL_W-1:0] sel;
    logic [CTRL_W-1:0]        ctrl_rdata;
    logic [CNT_W-1:0]         cnt_val [NUM_CNT];
    logic                     unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];

    perfmon_regs #(
        .NUM_CNT (NUM_CNT),
        .SEL_W   (SEL_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata[CTRL_W-1:0]),
        .wrap    (wrap),
        .run_all (run_all),
        .cnt_en  (cnt_en),
        .mask    (mask),
        .status  (status),
        .sel     (sel),
        .rdata   (ctrl_rdata)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign slot_hit[i] = (bus_addr == ADDR_W'(OFS_CNT + SLOT_BYTES * i));

        perfmon_counter #(
            .CNT_W   (CNT_W),
            .SEL_W   (SEL_W),
            .NUM_EVT (NUM_EVT)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_all && cnt_en[i]),
            .sel     (sel[i*SEL_W +: SEL_W]),
            .evt     (evt_pulse),
            .wr_en   (bus_wr && slot_hit[i]),
            .wr_data (bus_wdata[CNT_W-1:0]),
            .cnt     (cnt_val[i]),
            .wrap    (wrap[i])
        );
    end

    always_comb begin
        bus_rdata = DATA_W'(ctrl_rdata);
        for (int i = 0; i < NUM_CNT; i++) begin
            if (slot_hit[i]) bus_rdata = DATA_W'(cnt_val[i]);
        end
    end

    assign irq = |(status & ~mask);
endmodule

// File: tb/cache_perfmon_tb.sv
`timescale 1ns/1ps
module cache_perfmon_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [255:0] evt_pulse = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cache_perfmon u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .irq(irq)
    );

    // {write address, write data, read address, expected read}
    localparam int NT = 11;
    localparam logic [95:0] TBL [0:NT-1] = '{
        {16'h0800, 32'h0000005A, 16'h0800, 32'h0000005A},
        {16'h0800, 32'h000000FF, 16'h0800, 32'h000000FF},
        {16'h1D04, 32'h11223344, 16'h1D04, 32'h11223344},
        {16'h1D04, 32'hFFFFFFFF, 16'h1D04, 32'hFFFFFFFF},
        {16'h1C00, 32'h000001FF, 16'h1C00, 32'h000000FF},
        {16'h1C00, 32'h00000000, 16'h1C00, 32'h00000000},
        {16'h0408, 32'hFFFFFFFF, 16'h0408, 32'h00020000},
        {16'h0408, 32'h00000000, 16'h0408, 32'h00000000},
        {16'h0808, 32'hFFFFFFFF, 16'h0808, 32'h00000000},
        {16'h1D00, 32'h000000A5, 16'h1D00, 32'h000000A5},
        {16'h1D00, 32'hFFFFFFFF, 16'h1D00, 32'hFFFFFFFF}
    };
    string TAG [0:NT-1] = '{"R10", "R10", "R4", "R4", "R2", "R2", "R2", "R3", "R9", "R4", "R4"};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [63:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int code, input int n);
        @(negedge clk);
        evt_pulse[code] = 1'b1;
        repeat (n) @(negedge clk);
        evt_pulse[code] = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(16'h1E00, v); chk("R1 cnt0", v, 64'h0);
        rd(16'h1E38, v); chk("R1 cnt7", v, 64'h0);
        rd(16'h0800, v); chk("R1 mask", v, 64'hFF);
        rd(16'h1D00, v); chk("R1 sel0", v, 64'hFFFFFFFF);
        rd(16'h1D04, v); chk("R1 sel1", v, 64'hFFFFFFFF);
        rd(16'h0808, v); chk("R1 status", v, 64'h0);
        rd(16'h1C00, v); chk("R1 enables", v, 64'h0);
        rd(16'h0408, v); chk("R1 ctrl", v, 64'h0);
        chk("R1 irq", {63'h0, irq}, 64'h0);

        for (int i = 0; i < NT; i++) begin
            wr(TBL[i][95:80], {32'h0, TBL[i][79:48]});
            rd(TBL[i][47:32], v);
            chk(TAG[i], v, {32'h0, TBL[i][31:0]});
        end

        // counters 0 (code 0x02), 1 (0xFF), 3 (0x00), 5 (0x41)
        wr(16'h1D00, 64'h00FFFF02);
        wr(16'h1D04, 64'hFFFF41FF);
        wr(16'h1C00, 64'h2B);
        wr(16'h0408, 64'h20000);
        pulse(2, 5);
        rd(16'h1E00, v); chk("R2 cnt0 five pulses", v, 64'd5);
        pulse(8'h41, 3);
        rd(16'h1E28, v); chk("R4 cnt5 upper word lane1", v, 64'd3);
        rd(16'h1E00, v); chk("R4 cnt0 untouched", v, 64'd5);
        rd(16'h1E18, v); chk("R4 cnt3 untouched", v, 64'd0);

        pulse(255, 4);
        rd(16'h1E08, v); chk("R5 no-event code", v, 64'd0);

        wr(16'h0408, 64'h0);
        pulse(2, 4);
        rd(16'h1E00, v); chk("R3 global off", v, 64'd5);
        wr(16'h0408, 64'h20000);
        wr(16'h1C00, 64'h2A);
        pulse(2, 4);
        rd(16'h1E00, v); chk("R3 local off", v, 64'd5);
        pulse(8'h41, 2);
        rd(16'h1E28, v); chk("R2 cnt5 resumes", v, 64'd5);

        wr(16'h1E10, 64'hABCD_0000_1234_5678);
        rd(16'h1E10, v); chk("R6 upper bits", v, 64'h0000_0000_1234_5678);

        wr(16'h1C00, 64'h2B);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'h1E00; bus_wdata = 64'd100; evt_pulse[2] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse[2] = 1'b0;
        rd(16'h1E00, v); chk("R7 write wins", v, 64'd100);

        wr(16'h1E18, 64'h0000_FFFF_FFFF_FFFE);
        pulse(0, 2);
        rd(16'h1E18, v); chk("R8 wrapped", v, 64'd0);
        rd(16'h0808, v); chk("R8 status masked", v, 64'h08);
        chk("R10 masked irq", {63'h0, irq}, 64'h0);

        wr(16'h0800, 64'hF7);
        #1; chk("R10 unmasked irq", {63'h0, irq}, 64'h1);
        wr(16'h080C, 64'h0);
        rd(16'h0808, v); chk("R9 zero write", v, 64'h08);
        wr(16'h080C, 64'h08);
        rd(16'h0808, v); chk("R9 cleared", v, 64'h0);
        chk("R10 irq low", {63'h0, irq}, 64'h0);

        wr(16'h1E18, 64'h0000_FFFF_FFFF_FFFF);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'h080C; bus_wdata = 64'h08; evt_pulse[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse[0] = 1'b0;
        rd(16'h0808, v); chk("R9 set wins", v, 64'h08);
        rd(16'h1E18, v); chk("R8 wrap at clear", v, 64'd0);
        chk("R10 irq set", {63'h0, irq}, 64'h1);
        wr(16'h0800, 64'hFF);
        #1; chk("R10 remasked", {63'h0, irq}, 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule